// File: doc/BRIEF.md
# Data Address Watchpoint Comparator

This block watches the data addresses that a processor's load/store pipeline presents. Each memory-access instruction reaches it with its computed address, a read-type or write-type class, a flag that marks a cache-management operation, and an optional request to force alignment to an operand size. The block checks the address against two programmable compare registers. When an enabled match occurs, it records the match in sticky status bits and raises a one-cycle event pulse. The pipeline keeps running: the block only reports.

A mode input sets how the two registers are used. They can act as two independent exact-address watchpoints. They can also be linked as a pair that describes an address interval, matching either inside or outside it. In the last mode the pair is an address plus a bit mask, and the mask picks which address bits are compared. Software clears the status bits by writing ones on a clear input.

Top module: `dac_watch_top`

## Requirements
- R1: While `rst_n` is low, `sts` and `evt` are held at zero, and both read zero on the first cycle after reset is released.
- R2: With `cfg_mode` = 0 (independent), comparator 1 matches when the compare address equals `cfg_cmp1`, and comparator 2 matches when it equals `cfg_cmp2`. Each is judged on its own.
- R3: `cfg_en` and `sts` share one bit layout: bit 0 = comparator 1 read, bit 1 = comparator 1 write, bit 2 = comparator 2 read, bit 3 = comparator 2 write. An access with `acc_is_write` = 0 is a read and one with `acc_is_write` = 1 is a write. A status bit is set only when its enable bit is 1.
- R4: With `cfg_mode` = 1 (inside interval), the pair matches when `cfg_cmp1` <= address < `cfg_cmp2`, compared unsigned.
- R5: With `cfg_mode` = 2 (outside interval), the pair matches when the address is below `cfg_cmp1` or at or above `cfg_cmp2`.
- R6: With `cfg_mode` = 3 (masked), the pair matches when every address bit whose `cfg_cmp2` bit is 1 equals the same bit of `cfg_cmp1`.
- R7: In the paired modes (1, 2 and 3), a match sets both status bits of the access type (bits 0 and 2 for a read, bits 1 and 3 for a write). The enables used are bit 0 for reads and bit 1 for writes. Bits 2 and 3 of `cfg_en` have no effect in these modes.
- R8: When `acc_is_cache` = 1, the full computed address is compared, and `acc_align` is ignored.
- R9: For a non-cache access with `acc_align` = 1, the low `acc_size` address bits are zeroed before the compare. An `acc_size` of n means an operand of 2^n bytes.
- R10: A set status bit stays set until a 1 is written to the same bit of `clr_w1c`. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: Status updates are visible on the cycle after the access is presented. `evt` is high for exactly that one cycle when at least one status bit is being set by the access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Compare arrangement (0 independent, 1 inside, 2 outside, 3 masked) |
| cfg_en | input | 4 | Per-comparator read/write enables |
| cfg_cmp1 | input | ADDR_W | Compare register 1 (exact address, interval low bound, or masked reference) |
| cfg_cmp2 | input | ADDR_W | Compare register 2 (exact address, interval high bound, or mask) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Computed data address |
| acc_is_write | input | 1 | 1 = write-type access, 0 = read-type |
| acc_is_cache | input | 1 | Cache-management operation |
| acc_align | input | 1 | Request to force operand-size alignment |
| acc_size | input | SIZE_W | Log2 of the operand size in bytes |
| clr_w1c | input | 4 | Write-one-to-clear for the status bits |
| sts | output | 4 | Sticky match status |
| evt | output | 1 | One-cycle match event |

## Verification
The bench builds the block with a 32-bit address and a 3-bit operand-size field. With these values, forced alignment can clear up to seven low address bits, and unsigned interval bounds can sit anywhere in the full 32-bit range. Directed cases test the exact edges of each interval bound, a mask that ignores the low half of the address, cache operations that also carry an alignment request, and a clear that lands in the same cycle as a set. A mixed random stream then runs all four modes, with addresses drawn next to the compare values.

// File: rtl/dac_watch_pkg.sv
// Package: shared encodings for the data address watchpoint comparator.
// Assumes status and enable vectors share the layout {2W, 2R, 1W, 1R}.
package dac_watch_pkg;

    typedef enum logic [1:0] {
        MODE_INDEP   = 2'd0,
        MODE_INSIDE  = 2'd1,
        MODE_OUTSIDE = 2'd2,
        MODE_MASKED  = 2'd3
    } cmp_mode_e;

    localparam int NUM_CMP  = 2;
    localparam int NUM_STS  = 2 * NUM_CMP;
    localparam int IDX_1R   = 0;
    localparam int IDX_1W   = 1;
    localparam int IDX_2R   = 2;
    localparam int IDX_2W   = 3;

    // Index of the read bit of comparator k in enable/status vectors.
    function automatic int rd_idx(input int k);
        return 2 * k;
    endfunction

    // Index of the write bit of comparator k in enable/status vectors.
    function automatic int wr_idx(input int k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/dac_addr_prep.sv
// Module: dac_addr_prep
// Builds the address used for comparison. A non-cache access that asks
// for forced alignment has its low SIZE bits cleared. A cache-management
// operation always keeps its full computed address.
// Assumes acc_size values above ADDR_W simply clear the whole address.
module dac_addr_prep #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic [ADDR_W-1:0] raw_addr,
    input  logic              is_cache,
    input  logic              force_align,
    input  logic [SIZE_W-1:0] size_log2,
    output logic [ADDR_W-1:0] cmp_addr
);

    logic [ADDR_W-1:0] low_mask;
    logic              apply_align;

    // Thermometer mask covering the low size_log2 bits.
    always_comb begin
        low_mask = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (b < int'(size_log2)) begin
                low_mask[b] = 1'b1;
            end
        end
    end

    // Alignment applies only to non-cache accesses that request it.
    always_comb begin
        apply_align = force_align && !is_cache;
    end

    // Select the aligned or the untouched address.
    always_comb begin
        if (apply_align) begin
            cmp_addr = raw_addr & ~low_mask;
        end else begin
            cmp_addr = raw_addr;
        end
    end

endmodule

// File: rtl/dac_match.sv
// Module: dac_match
// Compares the prepared address with the two compare registers under the
// selected arrangement and produces the status bits to set this cycle.
// Assumes the interval compare is unsigned, with an inclusive low bound
// and an exclusive high bound. In the paired modes only the enables of
// comparator 1 are used.
module dac_match
    import dac_watch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  cmp1,
    input  logic [ADDR_W-1:0]  cmp2,
    input  logic [1:0]         mode,
    input  logic [NUM_STS-1:0] en,
    input  logic               valid,
    input  logic               is_write,
    output logic [NUM_STS-1:0] set_req
);

    logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_regs;
    logic [NUM_CMP-1:0]             exact_hit;
    logic [NUM_CMP-1:0]             cmp_hit;
    logic [NUM_CMP-1:0]             en_rd;
    logic [NUM_CMP-1:0]             en_wr;
    logic                           above_low;
    logic                           below_high;
    logic                           inside_hit;
    logic                           mask_hit;
    logic                           pair_hit;
    cmp_mode_e                      mode_q;

    // Gather the compare registers so that the exact compares repeat.
    always_comb begin
        cmp_regs[0] = cmp1;
        cmp_regs[1] = cmp2;
        mode_q      = cmp_mode_e'(mode);
    end

    // One equality comparator per compare register.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_exact
        always_comb begin
            exact_hit[k] = (addr == cmp_regs[k]);
        end
    end

    // Interval bounds for the two range arrangements.
    always_comb begin
        above_low  = (addr >= cmp1);
        below_high = (addr < cmp2);
        inside_hit = above_low && below_high;
    end

    // Masked compare: only bits selected in cmp2 must agree with cmp1.
    always_comb begin
        mask_hit = (((addr ^ cmp1) & cmp2) == '0);
    end

    // Pair result for the selected paired arrangement.
    always_comb begin
        unique case (mode_q)
            MODE_INSIDE:  pair_hit = inside_hit;
            MODE_OUTSIDE: pair_hit = !inside_hit;
            MODE_MASKED:  pair_hit = mask_hit;
            default:      pair_hit = 1'b0;
        endcase
    end

    // Route per-comparator hits and enables according to the arrangement.
    always_comb begin
        if (mode_q == MODE_INDEP) begin
            cmp_hit = exact_hit;
            for (int k = 0; k < NUM_CMP; k++) begin
                en_rd[k] = en[rd_idx(k)];
                en_wr[k] = en[wr_idx(k)];
            end
        end else begin
            cmp_hit = {NUM_CMP{pair_hit}};
            en_rd   = {NUM_CMP{en[IDX_1R]}};
            en_wr   = {NUM_CMP{en[IDX_1W]}};
        end
    end

    // Qualify each comparator hit by access class and enable.
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_qual
        always_comb begin
            set_req[rd_idx(k)] = valid && cmp_hit[k] && !is_write && en_rd[k];
            set_req[wr_idx(k)] = valid && cmp_hit[k] &&  is_write && en_wr[k];
        end
    end

endmodule

// File: rtl/dac_status.sv
// Module: dac_status
// Holds the sticky match status and the one-cycle event pulse.
// Assumes that a set wins over a clear on the same bit in the same cycle.
module dac_status
    import dac_watch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_STS-1:0] set_req,
    input  logic [NUM_STS-1:0] clr_req,
    output logic [NUM_STS-1:0] sts,
    output logic               evt
);

    logic [NUM_STS-1:0] sts_next;

    // Next status: clear the requested bits first, then apply the sets.
    always_comb begin
        sts_next = (sts & ~clr_req) | set_req;
    end

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
        end else begin
            sts <= sts_next;
        end
    end

    // Event pulse, high for the cycle after any bit is being set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= 1'b0;
        end else begin
            evt <= |set_req;
        end
    end

endmodule

// File: rtl/dac_watch_top.sv
// Module: dac_watch_top
// Data address watchpoint comparator. It prepares the access address,
// matches it against two compare registers, and records sticky status
// along with an event pulse.
// Assumes the configuration inputs are held steady by the register owner.
module dac_watch_top
    import dac_watch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [3:0]        cfg_en,
    input  logic [ADDR_W-1:0] cfg_cmp1,
    input  logic [ADDR_W-1:0] cfg_cmp2,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_is_write,
    input  logic              acc_is_cache,
    input  logic              acc_align,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [3:0]        clr_w1c,
    output logic [3:0]        sts,
    output logic              evt
);

    logic [ADDR_W-1:0]  cmp_addr;
    logic [NUM_STS-1:0] set_req;

    dac_addr_prep #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_prep (
        .raw_addr    (acc_addr),
        .is_cache    (acc_is_cache),
        .force_align (acc_align),
        .size_log2   (acc_size),
        .cmp_addr    (cmp_addr)
    );

    dac_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .addr     (cmp_addr),
        .cmp1     (cfg_cmp1),
        .cmp2     (cfg_cmp2),
        .mode     (cfg_mode),
        .en       (cfg_en),
        .valid    (acc_valid),
        .is_write (acc_is_write),
        .set_req  (set_req)
    );

    dac_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_w1c),
        .sts     (sts),
        .evt     (evt)
    );

endmodule

// File: rtl/dac_watch_chk.sv
// Module: dac_watch_chk
// Checker bound to dac_watch_top. It watches the ports and the set
// requests that the match logic hands to the status register.
module dac_watch_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [3:0]        cfg_en,
    input logic              acc_valid,
    input logic              acc_is_write,
    input logic [3:0]        clr_w1c,
    input logic [3:0]        set_req,
    input logic [3:0]        sts,
    input logic              evt
);

    // R1: reset forces status and event low on the following cycle.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sts == 4'b0 && !evt));

    for (genvar i = 0; i < 4; i++) begin : g_bit
        // R10: a set bit with no clear stays set.
        assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[i] && !clr_w1c[i]) |=> sts[i]);
        // R10: a requested set is visible next cycle even under a clear.
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> sts[i]);
        // R3: a disabled bit is never requested in independent mode.
        assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode == 2'd0 && !cfg_en[i]) |-> !set_req[i]);
    end

    // R11: no access means no event on the next cycle.
    assert_no_evt_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !evt);

    // R11: with no access and no clear the status is unchanged.
    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && clr_w1c == 4'b0) |=> $stable(sts));

    // R7: a paired-mode event leaves both bits of one access type set.
    assert_pair_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_mode != 2'd0) |=>
            (!evt || (sts[0] && sts[2]) || (sts[1] && sts[3])));

    // R3: a read access never requests a write status bit.
    assert_class_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_write) |-> (!set_req[1] && !set_req[3]));

endmodule

bind dac_watch_top dac_watch_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/dac_watch_top_tb.sv
// Bench for dac_watch_top: a behavioural model checked on every clock,
// plus directed checks against values worked out by hand.
module dac_watch_top_tb;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_mode = 2'd0;
    logic [3:0]        cfg_en = 4'h0;
    logic [ADDR_W-1:0] cfg_cmp1 = '0;
    logic [ADDR_W-1:0] cfg_cmp2 = '0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_is_write = 1'b0;
    logic              acc_is_cache = 1'b0;
    logic              acc_align = 1'b0;
    logic [SIZE_W-1:0] acc_size = '0;
    logic [3:0]        clr_w1c = 4'h0;
    logic [3:0]        sts;
    logic              evt;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    model_on = 0;
    string cur_req = "R1";
    logic [3:0] m_sts = 4'h0;
    logic       m_evt = 1'b0;

    dac_watch_top #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dut (.*);

    always #10 clk = ~clk;

    // Record one check and report it if it fails.
    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // Reference model: the status bits this access would set.
    function automatic logic [3:0] model_set();
        logic [31:0] a;
        logic        h1, h2;
        logic [3:0]  s;
        a = acc_addr;
        if (acc_align && !acc_is_cache) a = (a >> acc_size) << acc_size;
        s = 4'h0;
        if (!acc_valid) return s;
        if (cfg_mode == 2'd0) begin
            h1 = (a == cfg_cmp1);
            h2 = (a == cfg_cmp2);
            if (h1 && !acc_is_write && cfg_en[0]) s[0] = 1;
            if (h1 &&  acc_is_write && cfg_en[1]) s[1] = 1;
            if (h2 && !acc_is_write && cfg_en[2]) s[2] = 1;
            if (h2 &&  acc_is_write && cfg_en[3]) s[3] = 1;
        end else begin
            if (cfg_mode == 2'd1)      h1 = (a >= cfg_cmp1) && (a < cfg_cmp2);
            else if (cfg_mode == 2'd2) h1 = (a < cfg_cmp1) || (a >= cfg_cmp2);
            else                       h1 = ((a & cfg_cmp2) == (cfg_cmp1 & cfg_cmp2));
            if (h1 && !acc_is_write && cfg_en[0]) s = 4'b0101;
            if (h1 &&  acc_is_write && cfg_en[1]) s = 4'b1010;
        end
        return s;
    endfunction

    // Model state update at each rising edge.
    always @(posedge clk) begin
        logic [3:0] s;
        s = model_set();
        if (!rst_n) begin
            m_sts = 4'h0;
            m_evt = 1'b0;
        end else begin
            m_sts = (m_sts & ~clr_w1c) | s;
            m_evt = (s != 4'h0);
        end
    end

    // Compare outputs with the model on every falling edge; watchdog.
    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            check({cur_req, " model sts"}, {28'h0, sts}, {28'h0, m_sts});
            check({cur_req, " model evt"}, {31'h0, evt}, {31'h0, m_evt});
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Present one access (with an optional same-cycle clear); return at the
    // falling edge after capture, when the new status is visible.
    task automatic access(input logic [31:0] addr, input logic wr, input logic cache,
                          input logic align, input logic [2:0] size, input logic [3:0] clr);
        @(negedge clk);
        acc_valid = 1; acc_addr = addr; acc_is_write = wr;
        acc_is_cache = cache; acc_align = align; acc_size = size; clr_w1c = clr;
        @(negedge clk);
        acc_valid = 0; clr_w1c = 4'h0; acc_align = 0; acc_is_cache = 0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_w1c = 4'hF;
        @(negedge clk);
        clr_w1c = 4'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset sts", {28'h0, sts}, 32'h0);
        check("R1 reset evt", {31'h0, evt}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {27'h0, evt, sts}, 32'h0);
        model_on = 1;

        cur_req = "R2"; cfg_mode = 0; cfg_cmp1 = 32'h1000; cfg_cmp2 = 32'h2000; cfg_en = 4'hF;
        access(32'h1000, 0, 0, 0, 0, 0);
        check("R2 exact read cmp1", {28'h0, sts}, 32'h1);
        check("R11 evt pulse", {31'h0, evt}, 32'h1);
        @(negedge clk);
        check("R11 evt single cycle", {31'h0, evt}, 32'h0);
        check("R10 sticky hold", {28'h0, sts}, 32'h1);
        cur_req = "R3";
        access(32'h2000, 1, 0, 0, 0, 0);
        check("R3 write cmp2 bit3", {28'h0, sts}, 32'h9);
        cur_req = "R10"; clear_all();
        check("R10 w1c clear", {28'h0, sts}, 32'h0);
        cur_req = "R3"; cfg_en = 4'b1110;
        access(32'h1000, 0, 0, 0, 0, 0);
        check("R3 disabled enable", {27'h0, evt, sts}, 32'h0);

        cur_req = "R4"; cfg_mode = 1; cfg_cmp1 = 32'h100; cfg_cmp2 = 32'h200; cfg_en = 4'h3;
        access(32'h1FF, 0, 0, 0, 0, 0);
        check("R4 inside top edge", {28'h0, sts}, 32'h5);
        clear_all();
        access(32'h200, 0, 0, 0, 0, 0);
        check("R4 high bound excluded", {28'h0, sts}, 32'h0);
        access(32'h100, 0, 0, 0, 0, 0);
        check("R4 low bound included", {28'h0, sts}, 32'h5);
        clear_all();

        cur_req = "R5"; cfg_mode = 2;
        access(32'h200, 0, 0, 0, 0, 0);
        check("R5 outside at high bound", {28'h0, sts}, 32'h5);
        clear_all();
        access(32'h150, 1, 0, 0, 0, 0);
        check("R5 inside no match", {28'h0, sts}, 32'h0);

        cur_req = "R6"; cfg_mode = 3; cfg_cmp1 = 32'hABCD0000; cfg_cmp2 = 32'hFFFF0000;
        access(32'hABCD1234, 1, 0, 0, 0, 0);
        check("R6 masked write", {28'h0, sts}, 32'hA);
        clear_all();
        access(32'hABCE0000, 1, 0, 0, 0, 0);
        check("R6 masked miss", {28'h0, sts}, 32'h0);

        cur_req = "R7"; cfg_en = 4'b1100;
        access(32'hABCD0000, 1, 0, 0, 0, 0);
        check("R7 pair ignores en2 en3", {27'h0, evt, sts}, 32'h0);

        cur_req = "R8"; cfg_mode = 0; cfg_cmp1 = 32'h1004; cfg_cmp2 = 32'h0; cfg_en = 4'hF;
        access(32'h1004, 0, 1, 1, 3, 0);
        check("R8 cache keeps low bits", {28'h0, sts}, 32'h1);
        clear_all();
        cur_req = "R9";
        access(32'h1004, 0, 0, 1, 3, 0);
        check("R9 aligned misses cmp1", {28'h0, sts}, 32'h0);
        cfg_cmp2 = 32'h1000;
        access(32'h1004, 0, 0, 1, 3, 0);
        check("R9 aligned hits cmp2", {28'h0, sts}, 32'h4);
        clear_all();

        cur_req = "R10";
        access(32'h1004, 0, 0, 0, 0, 4'hF);
        check("R10 set beats clear", {28'h0, sts}, 32'h1);
        clear_all();

        cur_req = "R2 R4 R5 R6 R8 R9 mixed";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] base;
            @(negedge clk);
            if (i % 50 == 0) begin
                cfg_mode = 2'($urandom_range(0, 3));
                cfg_en = 4'($urandom);
                cfg_cmp1 = $urandom & 32'hFFFF_FF00;
                cfg_cmp2 = cfg_cmp1 + ($urandom & 32'h3FF);
            end
            base = ($urandom_range(0, 1) == 0) ? cfg_cmp1 : cfg_cmp2;
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_addr = base + 32'($urandom_range(0, 9)) - 32'd4;
            acc_is_write = 1'($urandom);
            acc_is_cache = 1'($urandom);
            acc_align = 1'($urandom);
            acc_size = 3'($urandom);
            clr_w1c = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
        end
        @(negedge clk);
        acc_valid = 0; clr_w1c = 0;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule